// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block sends bytes as asynchronous serial frames. The host writes a byte into a holding register. A separate shift register turns that byte into a frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts sixteen ticks of an oversampling enable (`tick`), a one-cycle pulse that runs at sixteen times the bit rate. Because the block has two registers, the host can queue the next byte while the current frame is still being sent.

The moment the holding register hands its byte to the shift register is set by counting ticks. If the shift register is idle, the handoff happens on the fourth tick after the write and the start bit goes out on the fifth. If the shift register is busy, a byte that arrives early enough is handed over inside the current stop bit, so the next frame follows with no idle gap. An active-low clear-to-send input can hold back any handoff. The holding-register-empty flag is also shown as one bit of an 8-bit status word.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `tbe` is 1 and `status` is 8'h40.
- R2: A frame is a 0 start bit, then the eight data bits with bit 0 first, then a 1 stop bit. Each bit holds for 16 ticks, and `txd` changes only on a tick edge.
- R3: When the shift register is idle and `cts_n` is 0, `tbe` rises on the 4th tick after the edge that accepts the write.
- R4: In the same case as R3, `txd` falls to begin the start bit on the 5th tick after that write.
- R5: When the holding register is full and `cts_n` is 0 at the 12th tick of a stop bit, `tbe` rises on the 15th tick of that stop bit. A write accepted on or before that 12th-tick edge counts as full.
- R6: A byte handed over as in R5 has its start bit begin on the 16th tick of the stop bit, so there is no idle time between the two frames.
- R7: A byte written after the 12th stop-bit tick is treated as a write to an idle shifter. The block counts four ticks after the frame ends (then `tbe` rises) and five ticks (then the start bit begins).
- R8: While `cts_n` is 1, a byte waiting for an idle shifter is not handed over. `tbe` stays 0 and `txd` stays 1.
- R9: Once `cts_n` goes to 0 with a byte waiting, `tbe` rises on the 4th tick and the start bit begins on the 5th tick, counting ticks from the first edge at which `cts_n` is 0.
- R10: If `cts_n` is 1 at either the 12th or the 15th tick of a stop bit, the waiting byte is not chained. The line goes idle, the byte stays in the holding register, and it is sent later as described in R9.
- R11: Bit 6 of `status` equals `tbe` in every cycle, and all other status bits are 0.
- R12: Raising `cts_n` partway through a frame does not change that frame.
- R13: A write clears `tbe` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable at 16 times the bit rate |
| wr_en | input | 1 | Host write strobe, one cycle long |
| wr_data | input | 8 | Byte to be sent |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output, high when idle |
| tbe | output | 1 | Holding register empty |
| status | output | 8 | Status word; bit 6 holds `tbe` |

## Verification
Every due time is counted in ticks from a reference event. For writes to an idle shifter, the reference is the edge that accepts the write. After a release of `cts_n`, counting starts from the first edge at which `cts_n` is low. In a chained frame, the reference is the frame's start tick: the stop bit's 12th, 15th and 16th ticks fall at offsets 156, 159 and 160. The bench keeps its own count of tick edges. It samples at the falling clock edge right after the tick that is due, and also on the tick just before it, so a result that arrives one tick early or one tick late is caught. Frame bits are sampled at the middle of each 16-tick bit.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

    // Shift-register sequencer states
    typedef enum logic [2:0] {
        SH_IDLE,
        SH_ARM,     // byte loaded, waiting one tick before the start bit
        SH_START,
        SH_DATA,
        SH_STOP
    } sh_state_e;

    localparam int DEF_DATA_BITS  = 8;
    localparam int DEF_OVERSAMPLE = 16;
    localparam int DEF_HANDOFF    = 4;
    localparam int DEF_DEADLINE   = 12;
    localparam int DEF_STAT_W     = 8;
    localparam int DEF_TBE_BIT    = 6;

    // Line level for each sequencer state (data bits use the shift register LSB)
    function automatic logic line_level(sh_state_e st, logic lsb);
        case (st)
            SH_START: return 1'b0;
            SH_DATA:  return lsb;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/txb_hold.sv
module txb_hold #(
    parameter int W = uart_dbtx_pkg::DEF_DATA_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en)      full <= 1'b1;
            else if (take)  full <= 1'b0;
            if (wr_en)      data <= wr_data;
        end
    end
endmodule

// File: rtl/txb_launch.sv
module txb_launch #(
    parameter int HANDOFF_TICKS = uart_dbtx_pkg::DEF_HANDOFF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wr_en,
    input  logic full,
    input  logic sh_idle,
    input  logic cts_n,
    output logic take_idle
);
    localparam int CW = $clog2(HANDOFF_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HANDOFF_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          armed;

    assign armed     = full && sh_idle && !cts_n;
    assign take_idle = armed && tick && !wr_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !armed || wr_en)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/txb_serial.sv
module txb_serial
    import uart_dbtx_pkg::*;
#(
    parameter int W            = DEF_DATA_BITS,
    parameter int OVERSAMPLE   = DEF_OVERSAMPLE,
    parameter int DEADLINE_TICK = DEF_DEADLINE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cts_n,
    input  logic         wr_en,
    input  logic         buf_full,
    input  logic [W-1:0] buf_data,
    input  logic         take_idle,
    output logic         take_chain,
    output logic         sh_idle,
    output logic         txd
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);
    localparam logic [TW-1:0] T_LOAD = TW'(OVERSAMPLE - 2);
    localparam logic [TW-1:0] T_DEAD = TW'(DEADLINE_TICK - 1);
    localparam logic [BW-1:0] B_LAST = BW'(W - 1);

    sh_state_e     state;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bidx;
    logic [W-1:0]  shreg;
    logic          chain;
    logic          bit_end;

    assign bit_end    = tick && (tcnt == T_LAST);
    assign take_chain = (state == SH_STOP) && tick && (tcnt == T_LOAD) && chain && !cts_n;
    assign sh_idle    = (state == SH_IDLE);
    assign txd        = line_level(state, shreg[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            chain <= 1'b0;
        end else begin
            if (tick && state inside {SH_START, SH_DATA, SH_STOP})
                tcnt <= bit_end ? '0 : tcnt + 1'b1;
            case (state)
                SH_IDLE: if (take_idle) begin
                    shreg <= buf_data;
                    state <= SH_ARM;
                end
                SH_ARM: if (tick) begin
                    state <= SH_START;
                    tcnt  <= '0;
                end
                SH_START: if (bit_end) begin
                    state <= SH_DATA;
                    bidx  <= '0;
                end
                SH_DATA: if (bit_end) begin
                    shreg <= shreg >> 1;
                    if (bidx == B_LAST) state <= SH_STOP;
                    else                bidx  <= bidx + 1'b1;
                end
                SH_STOP: if (tick) begin
                    if (tcnt == T_DEAD)
                        chain <= (buf_full || wr_en) && !cts_n;
                    if (take_chain)
                        shreg <= buf_data;
                    else if (tcnt == T_LOAD)
                        chain <= 1'b0;
                    if (bit_end) begin
                        state <= chain ? SH_START : SH_IDLE;
                        chain <= 1'b0;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import uart_dbtx_pkg::*;
#(
    parameter int DATA_BITS     = DEF_DATA_BITS,
    parameter int OVERSAMPLE    = DEF_OVERSAMPLE,
    parameter int HANDOFF_TICKS = DEF_HANDOFF,
    parameter int DEADLINE_TICK = DEF_DEADLINE,
    parameter int STAT_W        = DEF_STAT_W,
    parameter int TBE_BIT       = DEF_TBE_BIT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 cts_n,
    output logic                 txd,
    output logic                 tbe,
    output logic [STAT_W-1:0]    status
);
    logic                 buf_full;
    logic [DATA_BITS-1:0] buf_data;
    logic                 take_idle;
    logic                 take_chain;
    logic                 sh_idle;

    txb_hold #(.W(DATA_BITS)) hold_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(take_idle | take_chain), .full(buf_full), .data(buf_data)
    );

    txb_launch #(.HANDOFF_TICKS(HANDOFF_TICKS)) launch_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .full(buf_full),
        .sh_idle(sh_idle), .cts_n(cts_n), .take_idle(take_idle)
    );

    txb_serial #(
        .W(DATA_BITS), .OVERSAMPLE(OVERSAMPLE), .DEADLINE_TICK(DEADLINE_TICK)
    ) serial_i (
        .clk(clk), .rst(rst), .tick(tick), .cts_n(cts_n), .wr_en(wr_en),
        .buf_full(buf_full), .buf_data(buf_data), .take_idle(take_idle),
        .take_chain(take_chain), .sh_idle(sh_idle), .txd(txd)
    );

    assign tbe = !buf_full;

    always_comb begin
        status          = '0;
        status[TBE_BIT] = tbe;
    end
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk #(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic              cts_n,
    input logic              txd,
    input logic              tbe,
    input logic [STAT_W-1:0] status,
    input logic              take_idle,
    input logic              take_chain
);
    // R3
    tbe_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tbe) |-> $past(tick));

    // R9
    tbe_rise_needs_cts_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tbe) |-> !$past(cts_n));

    // R13
    tbe_fall_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tbe) |-> $past(wr_en));

    // R4
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> $past(tick));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(txd));

    // R11
    status_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status));

    // R6
    single_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_idle, take_chain}));
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk #(.STAT_W(STAT_W)) chk_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .cts_n(cts_n),
    .txd(txd), .tbe(tbe), .status(status),
    .take_idle(take_idle), .take_chain(take_chain)
);

// File: tb/dbuf_uart_tx_tb_top.sv
module dbuf_uart_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cts_n = 1'b0;
    logic       txd;
    logic       tbe;
    logic [7:0] status;

    int nchk = 0;
    int nerr = 0;
    int tick_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dbuf_uart_tx dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .cts_n(cts_n), .txd(txd), .tbe(tbe), .status(status)
    );

    // tick every third cycle
    always @(negedge clk) begin
        tick <= (cyc % 3 == 2);
        cyc  <= cyc + 1;
    end

    always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

    task automatic at_tick(input int n);
        while (tick_cnt < n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_line(input string tag, input logic exp);
        chk(tag, {7'b0, txd}, {7'b0, exp});
    endtask

    task automatic chk_tbe(input string tag, input logic exp);
        chk(tag, {7'b0, tbe}, {7'b0, exp});
        chk({tag, " R11 status"}, status, exp ? 8'h40 : 8'h00);
    endtask

    task automatic put(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int k);
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hFF;
        return 8'(k * 53) ^ 8'h5A;
    endfunction

    task automatic check_frame(input int s, input logic [7:0] d);
        at_tick(s);
        chk_line("R2 start edge", 1'b0);
        for (int b = 0; b < 10; b++) begin
            logic e;
            at_tick(s + 16 * b + 8);
            e = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : d[b-1];
            chk_line($sformatf("R2 frame %0h bit %0d", d, b), e);
        end
    endtask

    // write to an idle shifter; optionally queue another byte once tbe rises
    task automatic launch_idle(input logic [7:0] d, input bit has_next,
                               input logic [7:0] nxt, output int s);
        int base;
        put(d);
        chk_tbe("R13 write clears", 1'b0);
        base = tick_cnt;
        at_tick(base + 3);
        chk_tbe("R3 before 4th tick", 1'b0);
        at_tick(base + 4);
        chk_tbe("R3 at 4th tick", 1'b1);
        chk_line("R4 still idle at 4th", 1'b1);
        if (has_next) put(nxt);
        at_tick(base + 5);
        chk_line("R4 start at 5th", 1'b0);
        s = base + 5;
    endtask

    task automatic release_cts(input string tag, input bit has_next,
                               input logic [7:0] nxt, output int s);
        int base;
        cts_n = 1'b0;
        base  = tick_cnt;
        at_tick(base + 3);
        chk_tbe({tag, " R9 before 4th"}, 1'b0);
        at_tick(base + 4);
        chk_tbe({tag, " R9 at 4th"}, 1'b1);
        chk_line({tag, " R9 idle at 4th"}, 1'b1);
        if (has_next) put(nxt);
        at_tick(base + 5);
        chk_line({tag, " R9 start at 5th"}, 1'b0);
        s = base + 5;
    endtask

    initial begin
        int s;
        int c;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_line("R1 reset line", 1'b1);
        chk_tbe("R1 reset tbe", 1'b1);

        // chained sweep of eight bytes
        launch_idle(pat(0), 1'b1, pat(1), s);
        for (int k = 0; k < 8; k++) begin
            bit chained;
            chained = (k < 7);
            check_frame(s, pat(k));
            at_tick(s + 158);
            chk_tbe("R5 before 15th stop tick", !chained);
            at_tick(s + 159);
            chk_tbe("R5 at 15th stop tick", 1'b1);
            chk_line("R6 stop still high", 1'b1);
            if (k + 2 < 8) put(pat(k + 2));
            at_tick(s + 160);
            chk_line("R6 next start at 16th", !chained);
            s = s + 160;
        end

        // late write after the 12th stop tick
        at_tick(s + 4);
        launch_idle(8'hC3, 1'b0, 8'h00, s);
        check_frame(s, 8'hC3);
        at_tick(s + 156);
        put(8'h96);
        at_tick(s + 159);
        chk_tbe("R7 no chain at 15th", 1'b0);
        at_tick(s + 160);
        chk_line("R7 idle after frame", 1'b1);
        at_tick(s + 163);
        chk_tbe("R7 before 4th after idle", 1'b0);
        at_tick(s + 164);
        chk_tbe("R7 at 4th after idle", 1'b1);
        chk_line("R7 idle at 4th", 1'b1);
        at_tick(s + 165);
        chk_line("R7 start at 5th", 1'b0);
        s = s + 165;
        check_frame(s, 8'h96);

        // clear-to-send holds an idle handoff
        at_tick(s + 161);
        cts_n = 1'b1;
        put(8'h3A);
        c = tick_cnt;
        at_tick(c + 20);
        chk_tbe("R8 held", 1'b0);
        chk_line("R8 line idle", 1'b1);
        release_cts("idle", 1'b1, 8'h5C, s);

        // clear-to-send raised mid-frame: frame intact, no chain
        fork
            check_frame(s, 8'h3A);
            begin
                at_tick(s + 40);
                cts_n = 1'b1;
            end
        join
        chk_line("R12 frame kept", 1'b1);
        at_tick(s + 160);
        chk_line("R10 no start at 12th block", 1'b1);
        chk_tbe("R10 byte kept at 12th block", 1'b0);
        at_tick(s + 170);
        chk_line("R10 still idle", 1'b1);
        chk_tbe("R10 still full", 1'b0);
        release_cts("after 12th", 1'b1, 8'hE7, s);
        check_frame(s, 8'h5C);

        // clear-to-send raised between 12th and 15th stop ticks
        at_tick(s + 157);
        cts_n = 1'b1;
        at_tick(s + 159);
        chk_tbe("R10 blocked at 15th", 1'b0);
        at_tick(s + 160);
        chk_line("R10 no start at 16th", 1'b1);
        at_tick(s + 166);
        chk_line("R10 idle late", 1'b1);
        chk_tbe("R10 full late", 1'b0);
        release_cts("after 15th", 1'b0, 8'h00, s);
        check_frame(s, 8'hE7);

        at_tick(s + 170);
        chk_line("R2 idle high at end", 1'b1);
        chk_tbe("R1 empty at end", 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R2 actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule